// File: doc/BRIEF.md
# Interrupt Request Collector for an I/O Interrupt Controller

This block gathers interrupt requests for a 24-entry redirection table and passes them one at a time to a delivery interface. Requests come from two places. The first is sixteen external pins plus one internal hot-plug source, each passed through a two-flop synchronizer. The second is a memory write to the pin assertion offset, whose data byte names the entry to raise.

Each entry holds its own configuration: a vector, a destination, a mask, a trigger mode and a polarity. The pin path follows the entry's trigger mode and polarity. The write path is always treated as an edge and never looks at polarity. A valid request on an unmasked entry sets that entry's request bit.

A two-state arbiter picks the lowest-numbered pending entry. It then offers the entry's vector, destination and index on a request/acknowledge handshake.

- In `ARB_IDLE`, the arbiter takes the transition *grant*, moving to `ARB_OFFER`, when the delivery-enable bit is set and any entry is pending. On that transition it latches the winner's index, vector and destination.
- In `ARB_OFFER`, the arbiter holds the offer until `dlv_ack` arrives. It then takes the transition *retire* back to `ARB_IDLE`, and the acknowledged entry's request bit is cleared.

Level-mode entries also carry an in-service flag. The flag is set on acknowledge and cleared by an end-of-interrupt pulse that carries the entry's vector.

Top module: `ioapic_insert`

## Requirements
- R1: After reset, every entry is masked and has vector 0, destination 0, edge mode and active-high polarity. Delivery is disabled and `dlv_req` is low.
- R2: An edge-mode, active-high, unmasked entry sees a rising pin when delivery is enabled and the arbiter is idle. `dlv_req` then rises after the fourth rising clock edge that follows the pin change: two synchronizer stages, one detect cycle and one grant cycle. The offer carries that entry's index, vector and destination.
- R3: When `cfg_act_low`=1, the pin is inverted before detection. A falling pin is then an edge, and a low pin is the active level.
- R4: A masked entry never sets its request bit from a pin or a write. An edge that happens while the entry is masked is lost: unmasking it later does not raise a request.
- R5: A level-mode entry (`cfg_level`=1) requests while its pin is active. Once acknowledged, it is not raised again until `eoi_valid` is pulsed with `eoi_vector` equal to the entry's vector. After that pulse it requests again if the pin is still active.
- R6: A write with `mw_addr`=0x20 and `mw_data` < 24 sets the request bit of entry `mw_data` on the next edge, whatever that entry's polarity and trigger mode. A write to any other address, or with `mw_data` >= 24, changes nothing.
- R7: Pins 0 to 15 drive entries 0 to 15, and `hp_irq` drives entry 23. Entries 16 to 22 have no source and can be raised only by a write.
- R8: Writing `id_dt` with `id_we` sets the delivery-enable bit. While that bit is 0, no offer starts, and pending request bits are kept.
- R9: When several entries are pending, the lowest index is offered first.
- R10: An acknowledge while `dlv_req` is high clears the offered entry's request bit. If a new write or edge hits the same entry in the same cycle, the new event wins and the entry is offered again.
- R11: A pin held high on an unmasked, active-low, level-mode entry never produces a request.
- R12: While `dlv_req` is high and `dlv_ack` is low, `dlv_req`, `dlv_entry`, `dlv_vector` and `dlv_dest` stay unchanged. A configuration write during the offer does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one entry's configuration |
| cfg_idx | input | 5 | Entry index for the configuration write (>= 24 ignored) |
| cfg_vector | input | 8 | Vector to store |
| cfg_dest | input | 8 | Destination to store |
| cfg_mask | input | 1 | 1 = entry masked |
| cfg_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| cfg_act_low | input | 1 | 1 = pin active low |
| id_we | input | 1 | Write strobe for the delivery-enable bit |
| id_dt | input | 1 | Delivery-enable value |
| irq_pin | input | 16 | Asynchronous interrupt pins |
| hp_irq | input | 1 | Internal hot-plug source for entry 23 |
| mw_valid | input | 1 | Memory-write strobe |
| mw_addr | input | 8 | Memory-write offset |
| mw_data | input | 8 | Memory-write data: entry index |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| dlv_ack | input | 1 | Delivery acknowledge |
| dlv_req | output | 1 | Delivery request |
| dlv_entry | output | 5 | Index of the offered entry |
| dlv_vector | output | 8 | Vector of the offered entry |
| dlv_dest | output | 8 | Destination of the offered entry |

## Verification
The acknowledge that retires an offer and a fresh event for the same entry can land on one clock edge. The bench provokes this by raising `dlv_ack` and a pin-assertion write naming the offered entry in the same cycle. It then expects the entry to be offered again one cycle after the retire.

A level entry's acknowledge and its active pin also coincide. This is judged by the absence of a re-offer until the end-of-interrupt pulse arrives. A behavioural model, fed the same inputs, predicts `dlv_req` and the offer fields every cycle, so both collisions are judged cycle by cycle.

// File: rtl/ioapic_ins_pkg.sv
package ioapic_ins_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              act_low;
    } ent_cfg_t;

endpackage

// File: rtl/ioapic_pin_sync.sv
module ioapic_pin_sync #(
    parameter int N      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], raw[i]};
                end
            end

            assign synced[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ioapic_entry_bank.sv
module ioapic_entry_bank
    import ioapic_ins_pkg::*;
#(
    parameter int             N       = 24,
    parameter int             IDX_W   = 5,
    parameter logic [N-1:0]   HAS_SRC = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  ent_cfg_t            cfg_wr,
    input  logic [N-1:0]        synced,
    input  logic                mw_fire,
    input  logic [IDX_W-1:0]    mw_idx,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vector,
    input  logic                ack_fire,
    input  logic [IDX_W-1:0]    ack_idx,
    input  logic [IDX_W-1:0]    look_idx,
    output ent_cfg_t            look_cfg,
    output logic [N-1:0]        pend
);

    ent_cfg_t   cfg_q [N];
    logic [N-1:0] act, act_q, irr, rirr, set, clr, mw_hit, eoi_hit;

    localparam ent_cfg_t CFG_RST = '{vector: '0, dest: '0, mask: 1'b1,
                                     level: 1'b0, act_low: 1'b0};

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            assign act[i]     = HAS_SRC[i] & (synced[i] ^ cfg_q[i].act_low);
            assign clr[i]     = ack_fire && (ack_idx == IDX_W'(i));
            assign mw_hit[i]  = mw_fire && (mw_idx == IDX_W'(i));
            assign eoi_hit[i] = eoi_valid && (eoi_vector == cfg_q[i].vector);
            assign set[i]     = !cfg_q[i].mask &&
                                (mw_hit[i] ||
                                 (cfg_q[i].level ? (act[i] && !rirr[i] && !clr[i])
                                                 : (act[i] && !act_q[i])));
            assign pend[i]    = irr[i] && !cfg_q[i].mask;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[i] <= CFG_RST;
                    act_q[i] <= 1'b0;
                    irr[i]   <= 1'b0;
                    rirr[i]  <= 1'b0;
                end else begin
                    if (cfg_we && (cfg_idx == IDX_W'(i))) begin
                        cfg_q[i] <= cfg_wr;
                    end
                    act_q[i] <= act[i];
                    irr[i]   <= (irr[i] && !clr[i]) || set[i];
                    rirr[i]  <= (rirr[i] && !eoi_hit[i]) || (clr[i] && cfg_q[i].level);
                end
            end

            // R4
            mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irr[i]) |-> !$past(cfg_q[i].mask));

            // R10
            ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !irr[i]);
        end
    endgenerate

    assign look_cfg = cfg_q[look_idx];

endmodule

// File: rtl/ioapic_prio_arb.sv
module ioapic_prio_arb
    import ioapic_ins_pkg::*;
#(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dt_en,
    input  logic [N-1:0]        pend,
    output logic [IDX_W-1:0]    look_idx,
    input  ent_cfg_t            look_cfg,
    input  logic                dlv_ack,
    output logic                dlv_req,
    output logic [IDX_W-1:0]    dlv_entry,
    output logic [VEC_W-1:0]    dlv_vector,
    output logic [DEST_W-1:0]   dlv_dest,
    output logic                ack_fire,
    output logic [IDX_W-1:0]    ack_idx
);

    arb_state_e         st, st_n;
    logic [IDX_W-1:0]   ent_q;
    logic [VEC_W-1:0]   vec_q;
    logic [DEST_W-1:0]  dst_q;

    // lowest pending index wins
    always_comb begin
        look_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) look_idx = IDX_W'(i);
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ARB_IDLE:  if (dt_en && (|pend)) st_n = ARB_OFFER;
            ARB_OFFER: if (dlv_ack)          st_n = ARB_IDLE;
            default:                         st_n = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ARB_IDLE;
            ent_q <= '0;
            vec_q <= '0;
            dst_q <= '0;
        end else begin
            st <= st_n;
            if (st == ARB_IDLE && st_n == ARB_OFFER) begin
                ent_q <= look_idx;
                vec_q <= look_cfg.vector;
                dst_q <= look_cfg.dest;
            end
        end
    end

    always_comb begin
        dlv_req    = (st == ARB_OFFER);
        dlv_entry  = ent_q;
        dlv_vector = vec_q;
        dlv_dest   = dst_q;
        ack_fire   = dlv_req && dlv_ack;
        ack_idx    = ent_q;
    end

    // R12
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && !dlv_ack) |=> (dlv_req && $stable(dlv_entry) &&
                                   $stable(dlv_vector) && $stable(dlv_dest)));

    // R8
    gate_dt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_req) |-> $past(dt_en));

    // R9
    was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_req) |-> ((($past(pend) >> dlv_entry) & N'(1)) != '0));

endmodule

// File: rtl/ioapic_insert.sv
module ioapic_insert
    import ioapic_ins_pkg::*;
#(
    parameter int           NUM_ENT     = 24,
    parameter int           NUM_PINS    = 16,
    parameter int           HP_ENTRY    = 23,
    parameter int           SYNC_STAGES = 2,
    parameter int           ADDR_W      = 8,
    parameter logic [7:0]   PAR_OFFSET  = 8'h20,
    localparam int          IDX_W       = $clog2(NUM_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [VEC_W-1:0]     cfg_vector,
    input  logic [DEST_W-1:0]    cfg_dest,
    input  logic                 cfg_mask,
    input  logic                 cfg_level,
    input  logic                 cfg_act_low,
    input  logic                 id_we,
    input  logic                 id_dt,
    input  logic [NUM_PINS-1:0]  irq_pin,
    input  logic                 hp_irq,
    input  logic                 mw_valid,
    input  logic [ADDR_W-1:0]    mw_addr,
    input  logic [7:0]           mw_data,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector,
    input  logic                 dlv_ack,
    output logic                 dlv_req,
    output logic [IDX_W-1:0]     dlv_entry,
    output logic [VEC_W-1:0]     dlv_vector,
    output logic [DEST_W-1:0]    dlv_dest
);

    localparam logic [NUM_ENT-1:0] PIN_SET = NUM_ENT'((64'd1 << NUM_PINS) - 64'd1);
    localparam logic [NUM_ENT-1:0] HAS_SRC = PIN_SET | NUM_ENT'(64'd1 << HP_ENTRY);

    logic [NUM_ENT-1:0] raw, synced, pend;
    logic               dt_q, mw_fire, ack_fire;
    logic [IDX_W-1:0]   ack_idx, look_idx;
    ent_cfg_t           cfg_wr, look_cfg;

    generate
        for (genvar i = 0; i < NUM_ENT; i++) begin : g_src
            if (i < NUM_PINS) begin : g_pin
                assign raw[i] = irq_pin[i];
            end else if (i == HP_ENTRY) begin : g_hp
                assign raw[i] = hp_irq;
            end else begin : g_none
                assign raw[i] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dt_q <= 1'b0;
        else if (id_we) dt_q <= id_dt;
    end

    assign mw_fire = mw_valid && (mw_addr == ADDR_W'(PAR_OFFSET)) && (mw_data < 8'(NUM_ENT));

    assign cfg_wr.vector  = cfg_vector;
    assign cfg_wr.dest    = cfg_dest;
    assign cfg_wr.mask    = cfg_mask;
    assign cfg_wr.level   = cfg_level;
    assign cfg_wr.act_low = cfg_act_low;

    ioapic_pin_sync #(.N(NUM_ENT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw),
        .synced (synced)
    );

    ioapic_entry_bank #(.N(NUM_ENT), .IDX_W(IDX_W), .HAS_SRC(HAS_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wr     (cfg_wr),
        .synced     (synced),
        .mw_fire    (mw_fire),
        .mw_idx     (mw_data[IDX_W-1:0]),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .ack_fire   (ack_fire),
        .ack_idx    (ack_idx),
        .look_idx   (look_idx),
        .look_cfg   (look_cfg),
        .pend       (pend)
    );

    ioapic_prio_arb #(.N(NUM_ENT), .IDX_W(IDX_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .dt_en      (dt_q),
        .pend       (pend),
        .look_idx   (look_idx),
        .look_cfg   (look_cfg),
        .dlv_ack    (dlv_ack),
        .dlv_req    (dlv_req),
        .dlv_entry  (dlv_entry),
        .dlv_vector (dlv_vector),
        .dlv_dest   (dlv_dest),
        .ack_fire   (ack_fire),
        .ack_idx    (ack_idx)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dlv_req);

endmodule

// File: tb/ioapic_insert_tb.sv
module ioapic_insert_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [7:0]  cfg_vector = '0, cfg_dest = '0;
    logic        cfg_mask = 1'b0, cfg_level = 1'b0, cfg_act_low = 1'b0;
    logic        id_we = 1'b0, id_dt = 1'b0;
    logic [15:0] irq_pin = '1;
    logic        hp_irq = 1'b0;
    logic        mw_valid = 1'b0;
    logic [7:0]  mw_addr = '0, mw_data = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        dlv_ack = 1'b0;
    logic        dlv_req;
    logic [4:0]  dlv_entry;
    logic [7:0]  dlv_vector, dlv_dest;

    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    ioapic_insert u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_vector(cfg_vector), .cfg_dest(cfg_dest), .cfg_mask(cfg_mask),
        .cfg_level(cfg_level), .cfg_act_low(cfg_act_low), .id_we(id_we), .id_dt(id_dt),
        .irq_pin(irq_pin), .hp_irq(hp_irq), .mw_valid(mw_valid), .mw_addr(mw_addr),
        .mw_data(mw_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_ack(dlv_ack), .dlv_req(dlv_req), .dlv_entry(dlv_entry),
        .dlv_vector(dlv_vector), .dlv_dest(dlv_dest)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_s1[24], m_s2[24], m_aq[24], m_irr[24], m_ris[24];
    bit [7:0] m_vec[24], m_dst[24];
    bit       m_msk[24], m_lvl[24], m_low[24];
    bit       m_dt, m_busy;
    int       m_idx;
    bit [7:0] m_ov, m_od;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 24; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_aq[i] = 0; m_irr[i] = 0; m_ris[i] = 0;
                m_vec[i] = 0; m_dst[i] = 0; m_msk[i] = 1; m_lvl[i] = 0; m_low[i] = 0;
            end
            m_dt = 0; m_busy = 0; m_idx = 0; m_ov = 0; m_od = 0;
        end else begin
            bit act[24], nirr[24], nris[24], src[24];
            bit fire;
            int win;
            fire = m_busy && dlv_ack;
            for (int i = 0; i < 24; i++) begin
                bit has, clr, mw, st;
                has = (i < 16) || (i == 23);
                src[i] = (i < 16) ? irq_pin[i] : ((i == 23) ? hp_irq : 1'b0);
                act[i] = has && (m_s2[i] != m_low[i]);
                clr = fire && (m_idx == i);
                mw = mw_valid && (mw_addr == 8'h20) && (int'(mw_data) == i);
                if (m_lvl[i]) st = act[i] && !m_ris[i] && !clr;
                else          st = act[i] && !m_aq[i];
                st = !m_msk[i] && (mw || st);
                nirr[i] = (m_irr[i] && !clr) || st;
                nris[i] = (m_ris[i] && !(eoi_valid && eoi_vector == m_vec[i])) ||
                          (clr && m_lvl[i]);
            end
            if (!m_busy) begin
                win = -1;
                for (int i = 23; i >= 0; i--) if (m_irr[i] && !m_msk[i]) win = i;
                if (m_dt && win >= 0) begin
                    m_busy = 1; m_idx = win; m_ov = m_vec[win]; m_od = m_dst[win];
                end
            end else if (fire) begin
                m_busy = 0;
            end
            for (int i = 0; i < 24; i++) begin
                m_irr[i] = nirr[i]; m_ris[i] = nris[i]; m_aq[i] = act[i];
                m_s2[i] = m_s1[i]; m_s1[i] = src[i];
            end
            if (cfg_we && cfg_idx < 24) begin
                m_vec[cfg_idx] = cfg_vector; m_dst[cfg_idx] = cfg_dest;
                m_msk[cfg_idx] = cfg_mask; m_lvl[cfg_idx] = cfg_level;
                m_low[cfg_idx] = cfg_act_low;
            end
            if (id_we) m_dt = id_dt;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk(dlv_req == m_busy, {cur_tag, " req"}, dlv_req, m_busy);
            if (m_busy) begin
                chk(int'(dlv_entry) == m_idx, {cur_tag, " entry"}, dlv_entry, m_idx);
                chk(dlv_vector == m_ov, {cur_tag, " vector"}, dlv_vector, m_ov);
                chk(dlv_dest == m_od, {cur_tag, " dest"}, dlv_dest, m_od);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg(input int idx, input bit [7:0] v, input bit [7:0] d,
                       input bit msk, input bit lvl, input bit low);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 5'(idx); cfg_vector = v; cfg_dest = d;
        cfg_mask = msk; cfg_level = lvl; cfg_act_low = low;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_dt(input bit b);
        @(negedge clk); id_we = 1; id_dt = b;
        @(negedge clk); id_we = 0;
    endtask

    task automatic msg(input bit [7:0] a, input bit [7:0] d);
        @(negedge clk); mw_valid = 1; mw_addr = a; mw_data = d;
        @(negedge clk); mw_valid = 0;
    endtask

    task automatic eoi(input bit [7:0] v);
        @(negedge clk); eoi_valid = 1; eoi_vector = v;
        @(negedge clk); eoi_valid = 0;
    endtask

    task automatic expect_idle(input int n, input string tag);
        repeat (n) begin
            @(posedge clk); #5;
            chk(dlv_req == 0, tag, dlv_req, 0);
        end
    endtask

    task automatic wait_req(input string tag);
        int k = 0;
        do begin
            @(posedge clk); #5; k++;
        end while (!dlv_req && k < 15);
        chk(dlv_req == 1, {tag, " offer seen"}, dlv_req, 1);
    endtask

    task automatic take(input int ent, input bit [7:0] v, input bit [7:0] d, input string tag);
        wait_req(tag);
        chk(int'(dlv_entry) == ent, {tag, " entry"}, dlv_entry, ent);
        chk(dlv_vector == v, {tag, " vector"}, dlv_vector, v);
        chk(dlv_dest == d, {tag, " dest"}, dlv_dest, d);
        @(negedge clk); dlv_ack = 1;
        @(negedge clk); dlv_ack = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_tag = "R1";
        expect_idle(3, "R1 idle after reset");

        // R1: entries come out of reset masked, so a write does nothing
        set_dt(1);
        msg(8'h20, 8'd7);
        expect_idle(4, "R1 masked after reset");

        // R11: unused pin held high, active low level, unmasked
        cur_tag = "R11";
        cfg(5, 8'h45, 8'h05, 0, 1, 1);
        expect_idle(10, "R11 tied-high pin");

        // R2: exact latency on an edge entry
        cur_tag = "R2";
        cfg(0, 8'h30, 8'h11, 0, 0, 0);
        @(negedge clk); irq_pin[0] = 0;
        repeat (4) @(negedge clk);
        expect_idle(1, "R2 low pin");
        @(negedge clk); irq_pin[0] = 1;
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk); #5;
            chk(dlv_req == (k == 4), "R2 latency", dlv_req, (k == 4));
        end
        // R12: hold the offer unacknowledged while a config write lands
        cur_tag = "R12";
        cfg(0, 8'h99, 8'h99, 0, 0, 0);
        @(posedge clk); #5;
        chk(dlv_vector == 8'h30 && dlv_dest == 8'h11, "R12 held offer", dlv_vector, 8'h30);
        take(0, 8'h30, 8'h11, "R12");
        cfg(0, 8'h30, 8'h11, 0, 0, 0);

        // R3: active-low edge entry fires on a falling pin
        cur_tag = "R3";
        cfg(1, 8'h31, 8'h12, 0, 0, 1);
        expect_idle(4, "R3 high pin quiet");
        @(negedge clk); irq_pin[1] = 0;
        take(1, 8'h31, 8'h12, "R3");
        @(negedge clk); irq_pin[1] = 1;
        expect_idle(6, "R3 rising ignored");

        // R4: edge while masked is lost
        cur_tag = "R4";
        cfg(2, 8'h32, 8'h13, 1, 0, 0);
        @(negedge clk); irq_pin[2] = 0;
        repeat (3) @(negedge clk);
        irq_pin[2] = 1;
        expect_idle(6, "R4 masked edge");
        cfg(2, 8'h32, 8'h13, 0, 0, 0);
        expect_idle(6, "R4 unmask no replay");

        // R5: level entry with in-service hold and EOI
        cur_tag = "R5";
        cfg(3, 8'h33, 8'h14, 0, 1, 1);
        @(negedge clk); irq_pin[3] = 0;
        take(3, 8'h33, 8'h14, "R5 first");
        expect_idle(8, "R5 held until EOI");
        eoi(8'h34);
        expect_idle(4, "R5 wrong vector EOI");
        eoi(8'h33);
        take(3, 8'h33, 8'h14, "R5 after EOI");
        @(negedge clk); irq_pin[3] = 1;
        repeat (4) @(negedge clk);
        eoi(8'h33);
        expect_idle(6, "R5 pin released");

        // R6: message writes, polarity and trigger ignored
        cur_tag = "R6";
        cfg(20, 8'h50, 8'h22, 0, 1, 1);
        msg(8'h20, 8'd20);
        take(20, 8'h50, 8'h22, "R6 write");
        msg(8'h24, 8'd20);
        expect_idle(4, "R6 wrong offset");
        msg(8'h20, 8'd30);
        expect_idle(4, "R6 index too large");
        cfg(21, 8'h51, 8'h23, 1, 0, 0);
        msg(8'h20, 8'd21);
        expect_idle(4, "R6 masked write");

        // R7: hot-plug source on entry 23
        cur_tag = "R7";
        cfg(23, 8'h60, 8'h24, 0, 0, 0);
        @(negedge clk); hp_irq = 1;
        take(23, 8'h60, 8'h24, "R7 hot-plug");
        @(negedge clk); hp_irq = 0;
        expect_idle(4, "R7 quiet");

        // R8 + R9: pend several with delivery off, then release in order
        cur_tag = "R8";
        cfg(21, 8'h51, 8'h23, 0, 0, 0);
        cfg(16, 8'h40, 8'h25, 0, 0, 0);
        set_dt(0);
        msg(8'h20, 8'd21);
        msg(8'h20, 8'd20);
        msg(8'h20, 8'd16);
        expect_idle(5, "R8 delivery disabled");
        set_dt(1);
        cur_tag = "R9";
        take(16, 8'h40, 8'h25, "R9 first");
        take(20, 8'h50, 8'h22, "R9 second");
        take(21, 8'h51, 8'h23, "R9 third");
        expect_idle(4, "R9 drained");

        // R10: acknowledge and new event on the same entry in one cycle
        cur_tag = "R10";
        msg(8'h20, 8'd0);
        wait_req("R10 first");
        chk(dlv_entry == 5'd0, "R10 first entry", dlv_entry, 0);
        @(negedge clk);
        dlv_ack = 1; mw_valid = 1; mw_addr = 8'h20; mw_data = 8'd0;
        @(negedge clk);
        dlv_ack = 0; mw_valid = 0;
        @(posedge clk); #5;
        chk(dlv_req == 1 && dlv_entry == 5'd0, "R10 re-offer", dlv_req, 1);
        take(0, 8'h30, 8'h11, "R10 second");
        expect_idle(5, "R10 cleared");

        summary();
        $finish;
    end

endmodule